// File: doc/BRIEF.md
# Address-Address-Data Multiplexed Bus Master

This block drives a synchronous external bus on which one 16-bit set of wires carries, in turn, the upper half of a 32-bit address, the lower half of that address, and one data word. A local agent raises a one-cycle request with an address, a direction and write data. The block then runs one bus cycle and pulses `done`. On reads, the word that it captured is presented on `rdata`.

Every edge of chip select, address valid, output enable and write enable sits at a programmable count of bus-clock periods, measured from the start of the access. The bus clock is a divided copy of the functional clock. Output enable is low during the first address phase and high during the second, so a target can tell the two address words apart. If the first address-valid window ends exactly where the second one begins, address valid stays low across both phases as one pulse. If there is a gap between the two windows, it pulses low twice. A combinational configuration check rejects timing sets whose windows overlap or run out of order. While that check fails, the block does not start.

Top module: `aad_mux_master`

## Requirements
- R1: `cfg_div` picks the bus-clock period in functional-clock cycles: code 0 gives 1, code 1 gives 2, code 2 gives 4, and code 3 is flagged by the configuration check. For divide codes 1 and 2, `bus_clk` is high during the first half of each period. It is low while no access runs. For code 0, `bus_clk` is the functional clock gated by an active access.
- R2: A request is accepted when no access is running and `cfg_err` is low. Bus period 0 then starts in the next clock cycle. A request that arrives during an access is ignored.
- R3: `ad_oe` is high and `ad_out` carries `req_addr[31:16]` in the bus periods before `cfg_adv2_on`. From that period on, `ad_out` carries `req_addr[15:0]`.
- R4: `adv_n` is low in periods [`cfg_adv1_on`, `cfg_adv1_off`) and in periods [`cfg_adv2_on`, second off time), where the second off time is `cfg_adv2_rd_off` for reads and `cfg_adv2_wr_off` for writes. When `cfg_adv1_off` equals `cfg_adv2_on`, this forms one low pulse. When `cfg_adv2_on` is later, it forms two.
- R5: `oe_n` is low in periods [`cfg_oe1_on`, `cfg_oe1_off`) for both directions. On reads it is also low in periods [`cfg_oe_on`, `cfg_oe_off`). On reads, `ad_oe` drops from period `cfg_oe_on` onward.
- R6: On writes, `we_n` is low in periods [`cfg_adv2_on`, `cfg_adv2_wr_off`). From period `cfg_wdata_on` to the end of the access, `ad_out` carries `req_wdata` with `ad_oe` high.
- R7: `cs_n` is low in periods [`cfg_cs_on`, off), where off is `cfg_cs_rd_off` for reads and `cfg_cs_wr_off` for writes. With `cfg_cs_extra` set and a divide of 2 or 4, both edges of `cs_n` move half a bus period later. With a divide of 1, `cfg_cs_extra` has no effect.
- R8: On reads, `ad_in` is captured into `rdata` at the functional-clock edge that ends period `cfg_oe_off`-1.
- R9: `done` is high for exactly one cycle, in the cycle after the last functional-clock cycle of period `cfg_cycle_end`-1. In that cycle every strobe is high and `ad_oe` is low.
- R10: `cfg_err` is high when any of these holds: `cfg_adv1_off`<=`cfg_adv1_on`; `cfg_adv2_on`<`cfg_adv1_off`; either second off time <=`cfg_adv2_on`; `cfg_oe1_off`<=`cfg_oe1_on`; `cfg_oe1_off`>`cfg_adv2_on`; `cfg_oe_on`<`cfg_adv2_rd_off`; `cfg_oe_off`<=`cfg_oe_on`; `cfg_oe_off`>`cfg_cycle_end`; `cfg_wdata_on`<`cfg_adv2_wr_off`; a chip-select off time <=`cfg_cs_on` or >=`cfg_cycle_end`; `cfg_div`=3. While `cfg_err` is high, requests start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | functional clock |
| rst | input | 1 | synchronous active-high reset |
| cfg_div | input | 2 | bus clock divide code |
| cfg_cs_extra | input | 1 | half-period delay on chip-select edges |
| cfg_cs_on | input | 6 | chip-select assert period |
| cfg_cs_rd_off | input | 6 | chip-select release period, reads |
| cfg_cs_wr_off | input | 6 | chip-select release period, writes |
| cfg_adv1_on | input | 6 | first address-valid assert period |
| cfg_adv1_off | input | 6 | first address-valid release period |
| cfg_adv2_on | input | 6 | second address-valid assert period and lower-word start |
| cfg_adv2_rd_off | input | 6 | second address-valid release, reads |
| cfg_adv2_wr_off | input | 6 | second address-valid release, writes |
| cfg_oe1_on | input | 6 | first-phase output-enable assert period |
| cfg_oe1_off | input | 6 | first-phase output-enable release period |
| cfg_oe_on | input | 6 | read data output-enable assert period |
| cfg_oe_off | input | 6 | read data output-enable release period |
| cfg_wdata_on | input | 6 | period from which write data is driven |
| cfg_cycle_end | input | 6 | access length in bus periods |
| cfg_err | output | 1 | timing set rejected |
| req | input | 1 | start request |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 32 | access address |
| req_wdata | input | 16 | write data |
| done | output | 1 | access complete pulse |
| rdata | output | 16 | captured read data |
| bus_clk | output | 1 | bus clock |
| cs_n | output | 1 | chip select, active low |
| adv_n | output | 1 | address valid, active low |
| oe_n | output | 1 | output enable, active low |
| we_n | output | 1 | write enable, active low |
| ad_out | output | 16 | shared address/data value driven |
| ad_oe | output | 1 | drive enable for `ad_out` |
| ad_in | input | 16 | shared bus value returned |

## Verification
The bench keeps the default widths of a 16-bit word and 6-bit period counters, and changes the divide code and timing set from one access to the next. It uses divides of 1, 2 and 4. With them, the gated clock at divide 1, whole-period strobe edges, and the half-period chip-select shift all get exercised. Two timing sets are used. One has touching address-valid windows and the other leaves a gap between them, so both the single-pulse and the double-pulse shapes occur. Further accesses use an overlapping set or the reserved divide code, and one sends a request during a running access; these exercise the rejection and ignore paths.

// File: rtl/aad_pkg.sv
package aad_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned CNT_W  = 6;

  typedef enum logic [1:0] {
    DIV_BY1 = 2'd0,
    DIV_BY2 = 2'd1,
    DIV_BY4 = 2'd2,
    DIV_RSV = 2'd3
  } div_code_e;

  typedef enum logic [1:0] {
    BUS_HI_ADDR = 2'd0,
    BUS_LO_ADDR = 2'd1,
    BUS_DATA    = 2'd2
  } bus_sel_e;

  function automatic logic [1:0] div_last(input logic [1:0] code);
    case (code)
      DIV_BY2: div_last = 2'd1;
      DIV_BY4: div_last = 2'd3;
      default: div_last = 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/aad_cfg_check.sv
module aad_cfg_check #(
  parameter int unsigned TW = 6
) (
  input  logic [1:0]    div_code,
  input  logic [TW-1:0] cs_on,
  input  logic [TW-1:0] cs_rd_off,
  input  logic [TW-1:0] cs_wr_off,
  input  logic [TW-1:0] adv1_on,
  input  logic [TW-1:0] adv1_off,
  input  logic [TW-1:0] adv2_on,
  input  logic [TW-1:0] adv2_rd_off,
  input  logic [TW-1:0] adv2_wr_off,
  input  logic [TW-1:0] oe1_on,
  input  logic [TW-1:0] oe1_off,
  input  logic [TW-1:0] oe_on,
  input  logic [TW-1:0] oe_off,
  input  logic [TW-1:0] wdata_on,
  input  logic [TW-1:0] cycle_end,
  output logic          err
);
  logic addr_bad, oe_bad, cs_bad, div_bad;

  always_comb begin
    addr_bad = (adv1_off <= adv1_on) || (adv2_on < adv1_off) ||
               (adv2_rd_off <= adv2_on) || (adv2_wr_off <= adv2_on);
    oe_bad   = (oe1_off <= oe1_on) || (oe1_off > adv2_on) ||
               (oe_on < adv2_rd_off) || (oe_off <= oe_on) ||
               (oe_off > cycle_end) || (wdata_on < adv2_wr_off);
    cs_bad   = (cs_rd_off <= cs_on) || (cs_wr_off <= cs_on) ||
               (cs_rd_off >= cycle_end) || (cs_wr_off >= cycle_end);
    div_bad  = (div_code == aad_pkg::DIV_RSV);
    err      = addr_bad || oe_bad || cs_bad || div_bad;
  end
endmodule

// File: rtl/aad_timebase.sv
module aad_timebase #(
  parameter int unsigned TW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [1:0]    ph_last,
  input  logic [TW-1:0] cycle_end,
  output logic          act_q,
  output logic [TW-1:0] k_q,
  output logic [1:0]    ph_q,
  output logic          act_n,
  output logic [TW-1:0] k_n,
  output logic [1:0]    ph_n,
  output logic          period_end,
  output logic          final_edge
);
  logic [TW-1:0] k_inc;

  always_comb begin
    k_inc      = k_q + 1'b1;
    period_end = act_q && (ph_q == ph_last);
    final_edge = period_end && (k_inc == cycle_end);
    act_n = act_q;
    k_n   = k_q;
    ph_n  = ph_q;
    if (start) begin
      act_n = 1'b1;
      k_n   = '0;
      ph_n  = '0;
    end else if (act_q) begin
      if (period_end) begin
        ph_n = '0;
        if (final_edge) begin
          act_n = 1'b0;
          k_n   = '0;
        end else begin
          k_n = k_inc;
        end
      end else begin
        ph_n = ph_q + 2'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      k_q   <= '0;
      ph_q  <= '0;
    end else begin
      act_q <= act_n;
      k_q   <= k_n;
      ph_q  <= ph_n;
    end
  end
endmodule

// File: rtl/aad_strobe_gen.sv
module aad_strobe_gen #(
  parameter int unsigned TW = 6
) (
  input  logic          act,
  input  logic [TW-1:0] k,
  input  logic [1:0]    ph,
  input  logic          write,
  input  logic [1:0]    div_code,
  input  logic          cs_extra,
  input  logic [TW-1:0] cs_on,
  input  logic [TW-1:0] cs_rd_off,
  input  logic [TW-1:0] cs_wr_off,
  input  logic [TW-1:0] adv1_on,
  input  logic [TW-1:0] adv1_off,
  input  logic [TW-1:0] adv2_on,
  input  logic [TW-1:0] adv2_rd_off,
  input  logic [TW-1:0] adv2_wr_off,
  input  logic [TW-1:0] oe1_on,
  input  logic [TW-1:0] oe1_off,
  input  logic [TW-1:0] oe_on,
  input  logic [TW-1:0] oe_off,
  input  logic [TW-1:0] wdata_on,
  output logic          cs_lo,
  output logic          adv_lo,
  output logic          oe_lo,
  output logic          we_lo,
  output logic          drive,
  output aad_pkg::bus_sel_e sel,
  output logic          clk_hi
);
  import aad_pkg::*;

  function automatic logic in_win(input logic [TW-1:0] t, input logic [TW-1:0] on,
                                  input logic [TW-1:0] off);
    in_win = (t >= on) && (t < off);
  endfunction

  logic [1:0]    half;
  logic          late_half;
  logic [TW-1:0] cs_off, adv2_off, k_prev;
  logic          cs_win_now, cs_win_prev;

  always_comb begin
    half      = (div_code == DIV_BY4) ? 2'd2 : 2'd1;
    late_half = (ph >= half);
    cs_off    = write ? cs_wr_off : cs_rd_off;
    adv2_off  = write ? adv2_wr_off : adv2_rd_off;
    k_prev    = k - 1'b1;
    cs_win_now  = in_win(k, cs_on, cs_off);
    cs_win_prev = (k != '0) && in_win(k_prev, cs_on, cs_off);

    if (cs_extra && (div_code != DIV_BY1))
      cs_lo = act && (late_half ? cs_win_now : cs_win_prev);
    else
      cs_lo = act && cs_win_now;

    adv_lo = act && (in_win(k, adv1_on, adv1_off) || in_win(k, adv2_on, adv2_off));
    oe_lo  = act && (in_win(k, oe1_on, oe1_off) || (!write && in_win(k, oe_on, oe_off)));
    we_lo  = act && write && in_win(k, adv2_on, adv2_wr_off);

    sel   = BUS_HI_ADDR;
    drive = act;
    if (k >= adv2_on) begin
      if (write) begin
        sel = (k >= wdata_on) ? BUS_DATA : BUS_LO_ADDR;
      end else begin
        sel   = BUS_LO_ADDR;
        drive = act && (k < oe_on);
      end
    end

    clk_hi = act && (ph < half);
  end
endmodule

// File: rtl/aad_mux_master.sv
module aad_mux_master #(
  parameter int unsigned DW = 16,
  parameter int unsigned TW = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfg_div,
  input  logic              cfg_cs_extra,
  input  logic [TW-1:0]     cfg_cs_on,
  input  logic [TW-1:0]     cfg_cs_rd_off,
  input  logic [TW-1:0]     cfg_cs_wr_off,
  input  logic [TW-1:0]     cfg_adv1_on,
  input  logic [TW-1:0]     cfg_adv1_off,
  input  logic [TW-1:0]     cfg_adv2_on,
  input  logic [TW-1:0]     cfg_adv2_rd_off,
  input  logic [TW-1:0]     cfg_adv2_wr_off,
  input  logic [TW-1:0]     cfg_oe1_on,
  input  logic [TW-1:0]     cfg_oe1_off,
  input  logic [TW-1:0]     cfg_oe_on,
  input  logic [TW-1:0]     cfg_oe_off,
  input  logic [TW-1:0]     cfg_wdata_on,
  input  logic [TW-1:0]     cfg_cycle_end,
  output logic              cfg_err,
  input  logic              req,
  input  logic              req_write,
  input  logic [2*DW-1:0]   req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              done,
  output logic [DW-1:0]     rdata,
  output logic              bus_clk,
  output logic              cs_n,
  output logic              adv_n,
  output logic              oe_n,
  output logic              we_n,
  output logic [DW-1:0]     ad_out,
  output logic              ad_oe,
  input  logic [DW-1:0]     ad_in
);
  import aad_pkg::*;

  localparam int unsigned AW = 2 * DW;

  logic          start;
  logic          act_q, act_n, period_end, final_edge;
  logic [TW-1:0] k_q, k_n, rd_last;
  logic [1:0]    ph_q, ph_n;
  logic [AW-1:0] addr_q, addr_n;
  logic [DW-1:0] wd_q, wd_n;
  logic          wr_q, wr_n;
  logic          cs_lo, adv_lo, oe_lo, we_lo, drive, clk_hi;
  bus_sel_e      sel;
  logic          bclk_q;

  aad_cfg_check #(.TW(TW)) u_chk_cfg (
    .div_code(cfg_div), .cs_on(cfg_cs_on), .cs_rd_off(cfg_cs_rd_off),
    .cs_wr_off(cfg_cs_wr_off), .adv1_on(cfg_adv1_on), .adv1_off(cfg_adv1_off),
    .adv2_on(cfg_adv2_on), .adv2_rd_off(cfg_adv2_rd_off), .adv2_wr_off(cfg_adv2_wr_off),
    .oe1_on(cfg_oe1_on), .oe1_off(cfg_oe1_off), .oe_on(cfg_oe_on), .oe_off(cfg_oe_off),
    .wdata_on(cfg_wdata_on), .cycle_end(cfg_cycle_end), .err(cfg_err)
  );

  assign start = req && !act_q && !cfg_err;

  aad_timebase #(.TW(TW)) u_tb (
    .clk(clk), .rst(rst), .start(start), .ph_last(div_last(cfg_div)),
    .cycle_end(cfg_cycle_end), .act_q(act_q), .k_q(k_q), .ph_q(ph_q),
    .act_n(act_n), .k_n(k_n), .ph_n(ph_n), .period_end(period_end),
    .final_edge(final_edge)
  );

  always_comb begin
    addr_n = start ? req_addr  : addr_q;
    wd_n   = start ? req_wdata : wd_q;
    wr_n   = start ? req_write : wr_q;
  end

  aad_strobe_gen #(.TW(TW)) u_sg (
    .act(act_n), .k(k_n), .ph(ph_n), .write(wr_n), .div_code(cfg_div),
    .cs_extra(cfg_cs_extra), .cs_on(cfg_cs_on), .cs_rd_off(cfg_cs_rd_off),
    .cs_wr_off(cfg_cs_wr_off), .adv1_on(cfg_adv1_on), .adv1_off(cfg_adv1_off),
    .adv2_on(cfg_adv2_on), .adv2_rd_off(cfg_adv2_rd_off), .adv2_wr_off(cfg_adv2_wr_off),
    .oe1_on(cfg_oe1_on), .oe1_off(cfg_oe1_off), .oe_on(cfg_oe_on), .oe_off(cfg_oe_off),
    .wdata_on(cfg_wdata_on), .cs_lo(cs_lo), .adv_lo(adv_lo), .oe_lo(oe_lo),
    .we_lo(we_lo), .drive(drive), .sel(sel), .clk_hi(clk_hi)
  );

  assign rd_last = cfg_oe_off - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      wd_q   <= '0;
      wr_q   <= 1'b0;
      cs_n   <= 1'b1;
      adv_n  <= 1'b1;
      oe_n   <= 1'b1;
      we_n   <= 1'b1;
      ad_oe  <= 1'b0;
      ad_out <= '0;
      bclk_q <= 1'b0;
      done   <= 1'b0;
      rdata  <= '0;
    end else begin
      addr_q <= addr_n;
      wd_q   <= wd_n;
      wr_q   <= wr_n;
      cs_n   <= !cs_lo;
      adv_n  <= !adv_lo;
      oe_n   <= !oe_lo;
      we_n   <= !we_lo;
      ad_oe  <= drive;
      bclk_q <= clk_hi;
      done   <= final_edge;
      if (!drive)
        ad_out <= '0;
      else begin
        case (sel)
          BUS_HI_ADDR: ad_out <= addr_n[AW-1:DW];
          BUS_LO_ADDR: ad_out <= addr_n[DW-1:0];
          default:     ad_out <= wd_n;
        endcase
      end
      if (period_end && !wr_q && (k_q == rd_last))
        rdata <= ad_in;
    end
  end

  assign bus_clk = (cfg_div == DIV_BY1) ? (clk & act_q) : bclk_q;
endmodule

// File: rtl/aad_mux_master_chk.sv
module aad_mux_master_chk (
  input logic clk,
  input logic rst,
  input logic act,
  input logic req,
  input logic cfg_err,
  input logic done,
  input logic cs_n,
  input logic adv_n,
  input logic oe_n,
  input logic we_n,
  input logic ad_oe
);
  p_start_r2: assert property (@(posedge clk) disable iff (rst)
    (!act && req && !cfg_err) |=> act);

  p_refuse_r10: assert property (@(posedge clk) disable iff (rst)
    (!act && req && cfg_err) |=> !act);

  p_done_once_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_release_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> (cs_n && adv_n && oe_n && we_n && !ad_oe));

  p_we_oe_apart_r6: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> oe_n);
endmodule

bind aad_mux_master aad_mux_master_chk u_bind_chk (
  .clk(clk), .rst(rst), .act(act_q), .req(req), .cfg_err(cfg_err), .done(done),
  .cs_n(cs_n), .adv_n(adv_n), .oe_n(oe_n), .we_n(we_n), .ad_oe(ad_oe)
);

// File: tb/aad_mux_master_tb.sv
module aad_mux_master_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [1:0]  cfg_div = 2'd1;
  logic        cfg_cs_extra = 1'b0;
  logic [5:0]  c_cs_on, c_cs_rd, c_cs_wr, c_a1_on, c_a1_off, c_a2_on, c_a2_rd, c_a2_wr;
  logic [5:0]  c_o1_on, c_o1_off, c_oe_on, c_oe_off, c_wd_on, c_end;
  logic        cfg_err, req = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [15:0] req_wdata = '0, rdata, ad_out, ad_in;
  logic        done, bus_clk, cs_n, adv_n, oe_n, we_n, ad_oe;

  aad_mux_master dut_i (
    .clk(clk), .rst(rst), .cfg_div(cfg_div), .cfg_cs_extra(cfg_cs_extra),
    .cfg_cs_on(c_cs_on), .cfg_cs_rd_off(c_cs_rd), .cfg_cs_wr_off(c_cs_wr),
    .cfg_adv1_on(c_a1_on), .cfg_adv1_off(c_a1_off), .cfg_adv2_on(c_a2_on),
    .cfg_adv2_rd_off(c_a2_rd), .cfg_adv2_wr_off(c_a2_wr), .cfg_oe1_on(c_o1_on),
    .cfg_oe1_off(c_o1_off), .cfg_oe_on(c_oe_on), .cfg_oe_off(c_oe_off),
    .cfg_wdata_on(c_wd_on), .cfg_cycle_end(c_end), .cfg_err(cfg_err),
    .req(req), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .done(done), .rdata(rdata), .bus_clk(bus_clk), .cs_n(cs_n), .adv_n(adv_n),
    .oe_n(oe_n), .we_n(we_n), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in)
  );

  int total = 0, bad = 0, cyc = 0;
  logic [15:0] tgt_word = 16'hC3A5;
  assign ad_in = tgt_word;

  task automatic chk(input bit ok, input string tag, input int act_v, input int exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act_v, exp_v, cyc);
    end
  endtask

  function automatic int div_of(input logic [1:0] c);
    return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
  endfunction

  function automatic bit win(input int t, input int on, input int off);
    return (t >= on) && (t < off);
  endfunction

  function automatic bit exp_err();
    int e1 = c_a1_on, e2 = c_a1_off, e3 = c_a2_on;
    bit b = 0;
    if (e2 <= e1 || e3 < e2 || c_a2_rd <= c_a2_on || c_a2_wr <= c_a2_on) b = 1;
    if (c_o1_off <= c_o1_on || c_o1_off > c_a2_on || c_oe_on < c_a2_rd) b = 1;
    if (c_oe_off <= c_oe_on || c_oe_off > c_end || c_wd_on < c_a2_wr) b = 1;
    if (c_cs_rd <= c_cs_on || c_cs_wr <= c_cs_on || c_cs_rd >= c_end || c_cs_wr >= c_end) b = 1;
    if (cfg_div == 2'd3) b = 1;
    return b;
  endfunction

  // behavioural reference state
  int m_act = 0, m_k = 0, m_ph = 0, m_wr = 0, m_done = 0;
  logic [31:0] m_addr = '0;
  logic [15:0] m_wd = '0, m_rd = '0;

  always @(posedge clk) begin
    if (rst) begin
      m_act <= 0; m_k <= 0; m_ph <= 0; m_done <= 0; m_rd <= '0;
    end else begin
      m_done <= 0;
      if (m_act == 0) begin
        if (req && !exp_err()) begin
          m_act <= 1; m_k <= 0; m_ph <= 0;
          m_wr <= req_write; m_addr <= req_addr; m_wd <= req_wdata;
        end
      end else if (m_ph == div_of(cfg_div) - 1) begin
        if (m_wr == 0 && m_k == int'(c_oe_off) - 1) m_rd <= ad_in;
        m_ph <= 0;
        if (m_k + 1 == int'(c_end)) begin
          m_act <= 0; m_k <= 0; m_done <= 1;
        end else m_k <= m_k + 1;
      end else m_ph <= m_ph + 1;
    end
  end

  int adv_falls = 0;
  logic prev_adv = 1'b1;

  always @(negedge clk) begin
    int dv, hf, cs_off, a2_off;
    bit e_cs, e_adv, e_oe, e_we, e_drv, e_bclk;
    logic [15:0] e_bus;
    cyc++;
    if (!rst) begin
      dv = div_of(cfg_div);
      hf = dv / 2;
      cs_off = m_wr ? c_cs_wr : c_cs_rd;
      a2_off = m_wr ? c_a2_wr : c_a2_rd;
      e_cs = 0; e_adv = 0; e_oe = 0; e_we = 0; e_drv = 0; e_bclk = 0; e_bus = '0;
      if (m_act != 0) begin
        if (cfg_cs_extra && dv > 1)
          e_cs = (m_ph >= hf) ? win(m_k, c_cs_on, cs_off) : win(m_k - 1, c_cs_on, cs_off);
        else
          e_cs = win(m_k, c_cs_on, cs_off);
        e_adv = win(m_k, c_a1_on, c_a1_off) || win(m_k, c_a2_on, a2_off);
        e_oe  = win(m_k, c_o1_on, c_o1_off) || (m_wr == 0 && win(m_k, c_oe_on, c_oe_off));
        e_we  = (m_wr != 0) && win(m_k, c_a2_on, c_a2_wr);
        e_bclk = (dv > 1) && (m_ph < hf);
        if (m_k < int'(c_a2_on)) begin e_drv = 1; e_bus = m_addr[31:16]; end
        else if (m_wr != 0) begin
          e_drv = 1; e_bus = (m_k >= int'(c_wd_on)) ? m_wd : m_addr[15:0];
        end else begin
          e_drv = (m_k < int'(c_oe_on)); e_bus = m_addr[15:0];
        end
      end
      chk(cs_n == !e_cs, "R7 cs_n", cs_n, !e_cs);
      chk(adv_n == !e_adv, "R4 adv_n", adv_n, !e_adv);
      chk(oe_n == !e_oe, "R5 oe_n", oe_n, !e_oe);
      chk(we_n == !e_we, "R6 we_n", we_n, !e_we);
      chk(ad_oe == e_drv, "R3 ad_oe", ad_oe, e_drv);
      if (e_drv) chk(ad_out == e_bus, "R3/R6 ad_out", ad_out, e_bus);
      chk(bus_clk == e_bclk, "R1 bus_clk", bus_clk, e_bclk);
      chk(done == (m_done != 0), "R9 done", done, m_done);
      chk(rdata == m_rd, "R8 rdata", rdata, m_rd);
      chk(cfg_err == exp_err(), "R10 cfg_err", cfg_err, exp_err());
      if (prev_adv && !adv_n) adv_falls++;
      prev_adv = adv_n;
    end
  end

  task automatic set_timing(input int a2_on);
    c_cs_on = 0; c_cs_rd = 10; c_cs_wr = 9;
    c_a1_on = 0; c_a1_off = 2; c_a2_on = 6'(a2_on); c_a2_rd = 5; c_a2_wr = 5;
    c_o1_on = 0; c_o1_off = 2; c_oe_on = 6; c_oe_off = 9; c_wd_on = 5; c_end = 11;
  endtask

  task automatic access(input bit wr, input logic [31:0] a, input logic [15:0] d,
                        input int want_falls, input string tag);
    int n = 0;
    @(negedge clk);
    adv_falls = 0;
    req = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req = 1'b0;
    while (!done && n < 400) begin @(negedge clk); n++; end
    chk(done == 1'b1, {tag, " R9 done seen"}, done, 1);
    chk(adv_falls == want_falls, {tag, " R4 adv pulse count"}, adv_falls, want_falls);
    if (!wr) chk(rdata == tgt_word, {tag, " R8 read word"}, rdata, tgt_word);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    set_timing(3);
    repeat (3) @(negedge clk);
    chk(cs_n && adv_n && oe_n && we_n && !ad_oe && !done, "R9 reset idle", cs_n, 1);
    rst = 1'b0;
    @(negedge clk);
    chk(cfg_err == 1'b0, "R10 valid set accepted", cfg_err, 0);

    cfg_div = 2'd1; access(1, 32'h1234_5678, 16'hBEEF, 2, "wr div2 gap");
    cfg_div = 2'd2; set_timing(2); access(1, 32'hA5A5_0F0F, 16'h0110, 1, "wr div4 merged");
    cfg_div = 2'd0; set_timing(3); tgt_word = 16'h5AC3; access(0, 32'hDEAD_0001, 16'h0, 2, "rd div1");
    cfg_div = 2'd1; cfg_cs_extra = 1'b1; tgt_word = 16'h0F1E; access(0, 32'h0000_FFFF, 16'h0, 2, "rd div2 cs shift");
    cfg_div = 2'd0; access(1, 32'h7777_8888, 16'h9999, 2, "wr div1 extra ignored R7");
    cfg_div = 2'd2; set_timing(2); access(1, 32'hCAFE_F00D, 16'h4321, 1, "wr div4 cs shift");
    cfg_cs_extra = 1'b0;

    // R2: second request during an access is ignored
    cfg_div = 2'd1; set_timing(3);
    @(negedge clk);
    req = 1'b1; req_write = 1'b1; req_addr = 32'h1111_2222; req_wdata = 16'h3333;
    @(negedge clk); req_addr = 32'h9999_AAAA;
    @(negedge clk); req = 1'b0;
    for (int i = 0; i < 40; i++) @(negedge clk);
    chk(cs_n == 1'b1, "R2 busy request ignored", cs_n, 1);

    // R10: overlapping set refuses to start
    c_a2_on = 1;
    @(negedge clk);
    chk(cfg_err == 1'b1, "R10 overlap flagged", cfg_err, 1);
    req = 1'b1; req_write = 1'b0;
    @(negedge clk); req = 1'b0;
    begin
      int lows = 0;
      for (int i = 0; i < 30; i++) begin @(negedge clk); if (!cs_n || done) lows++; end
      chk(lows == 0, "R10 no access on error", lows, 0);
    end
    set_timing(3); cfg_div = 2'd3;
    @(negedge clk);
    chk(cfg_err == 1'b1, "R10 reserved divide flagged", cfg_err, 1);
    cfg_div = 2'd1;
    @(negedge clk);
    access(0, 32'h0BAD_CAFE, 16'h0, 2, "rd after error");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule